// File: doc/BRIEF.md
# Two-Wire Register Target with Upper-Range Write Spacing

This block is the target side of a two-wire serial bus (SCL clock, SDA open-drain data). A host uses it to reach a 256-entry byte-wide register file. Both bus lines are oversampled by the system clock and cleaned before the block looks for edges. The block recognises START, repeated START and STOP. It compares the received 7-bit device address against a fixed base whose lowest bit comes from a strap pin, and it acknowledges its own bytes by pulling SDA low. It never drives SCL and never stretches the clock.

A write transfer carries a register pointer in its first data byte. Every later byte is stored at the pointer, and the pointer then moves up by one and wraps from 0xFF to 0x00. A read transfer, usually reached through a repeated START after a pointer-setting write, returns bytes from the current pointer and moves the pointer up after each byte. The read continues while the host acknowledges and ends when the host withholds the acknowledge.

Registers 0xF0 to 0xFF are protected by a spacing guard. After an accepted write into this range, the next write into the range is accepted only once a window of `GUARD_US` microseconds has elapsed. A write that arrives too soon is still acknowledged on the bus, but it is dropped and a sticky violation flag is set. The `FAST_MODE` parameter selects the spike-filter length and the SDA output hold delay for the 400 kHz or the 100 kHz bus class.

Top module: `i2cs_regslave`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal 0x4C when `addr_sel` is 0, or 0x4D when `addr_sel` is 1. Bit 0 of that byte is R/W, with 1 meaning read.
- R2: An address that does not match is not acknowledged. The block then leaves SDA released for the rest of the transfer, including later bytes, until the next START.
- R3: In a write transfer, the first data byte loads the register pointer. Each later data byte is stored at the pointer, which then increments modulo 256. The block acknowledges every data byte.
- R4: A read transfer sends the byte at the pointer MSB first and increments the pointer after each byte. Another byte follows while the host acknowledges. A host NACK ends the read with SDA released.
- R5: A repeated START with no STOP before it restarts address decoding, and the register pointer is kept.
- R6: SDA is pulled low only while SCL is low. The SDA output never changes in the first cycle after the filtered SCL falls, and it changes only after a hold delay of at least 100 ns.
- R7: A write into 0xF0..0xFF that arrives while the spacing window is open is dropped, and the register keeps its value. It sets `guard_viol`, which stays 1 until reset.
- R8: A write into 0xF0..0xFF is accepted when no window is open, and each accepted write opens a new window of `GUARD_US` microseconds. Writes below 0xF0 are never blocked by the window.
- R9: After reset, SDA is released (`sda_oe` = 0) and `guard_viol` = 0.
- R10: A pulse on SCL or SDA that is shorter than the spike filter (50 ns in fast mode, 100 ns in standard mode) has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that supplies the low bit of the device address |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| guard_viol | output | 1 | Sticky flag: an upper-range write was dropped by the spacing guard |

## Verification
The embedded properties watch the bus-timing rules on every cycle. These rules are that SDA is only pulled low while SCL is low, that no output change happens right after an SCL fall, and that SDA stays silent during address reception. They also watch the guard: an accepted upper-range write always opens the window, a write during the window always raises the flag, and the flag never clears. Only the bench's transfers can show the data-path behaviour. This covers address matching under both strap values, pointer loading and auto-increment with wrap, sequential reads ended by a NACK, repeated START, rejection of a filtered glitch, and whether a dropped or accepted guarded write actually leaves the expected register contents.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Upper six bits of the device address; the strap supplies bit 0.
  localparam logic [5:0] DEV_BASE = 6'b100110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } bus_state_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_cnt;

  // Two-flop synchroniser, then a level must persist FILT_CYC cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      clean   <= 1'b1;
      run_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] != clean) begin
        if (run_cnt == CW'(FILT_CYC - 1)) begin
          clean   <= sync_q[1];
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cs_write_guard.sv
module i2cs_write_guard #(
  parameter int AW        = 8,
  parameter int GUARD_CYC = 65000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  output logic          wr_ok,
  output logic          viol
);
  localparam int CW = $clog2(GUARD_CYC + 1);

  logic [CW-1:0] win_cnt;
  logic          hi_rng;
  logic          busy;

  assign hi_rng = &wr_addr[AW-1:AW-4];
  assign busy   = (win_cnt != '0);
  assign wr_ok  = !(hi_rng && busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      viol    <= 1'b0;
    end else begin
      if (busy) win_cnt <= win_cnt - 1'b1;
      if (wr_req && hi_rng) begin
        if (busy) viol    <= 1'b1;
        else      win_cnt <= CW'(GUARD_CYC);
      end
    end
  end

  assert_window_opens_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && hi_rng && !busy) |=> busy);

  assert_early_write_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && hi_rng && busy) |=> viol);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);
endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
  import i2cs_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int FAST_MODE = 1,
  parameter int GUARD_US  = 650,
  parameter int AW        = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_sel,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic guard_viol
);
  localparam int CLK_MHZ   = CLK_HZ / 1_000_000;
  localparam int SPIKE_NS  = (FAST_MODE != 0) ? 50 : 100;
  localparam int HOLD_NS   = (FAST_MODE != 0) ? 150 : 400;
  localparam int FILT_CYC  = SPIKE_NS * CLK_MHZ / 1000 + 1;
  localparam int HOLD_CYC  = HOLD_NS * CLK_MHZ / 1000 + 1;
  localparam int GUARD_CYC = GUARD_US * CLK_MHZ;
  localparam int HCW       = $clog2(HOLD_CYC + 1);

  // Cleaned bus lines: index 0 = SCL, index 1 = SDA.
  logic [1:0] raw_lines;
  logic [1:0] clean_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_filt
    i2cs_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_lines[gi]),
      .clean(clean_lines[gi])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  bus_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sr;
  logic [7:0]    tx_sr;
  logic          rw_q;
  logic          first_q;
  logic          nack_q;
  logic [AW-1:0] ptr;
  logic          drv_tgt;
  logic          hold_pend;
  logic [HCW-1:0] hold_cnt;

  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wr_ok;
  logic [7:0]    rd_data;

  i2cs_regfile #(.AW(AW)) u_regs (
    .clk  (clk),
    .we   (wr_req & wr_ok),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(ptr),
    .rdata(rd_data)
  );

  i2cs_write_guard #(.AW(AW), .GUARD_CYC(GUARD_CYC)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_req),
    .wr_addr(wr_addr),
    .wr_ok  (wr_ok),
    .viol   (guard_viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      ptr       <= '0;
      drv_tgt   <= 1'b0;
      hold_pend <= 1'b0;
      hold_cnt  <= '0;
      sda_oe    <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      wr_req <= 1'b0;

      // Output update is deferred by the hold delay after each SCL fall.
      if (hold_pend) begin
        if (hold_cnt <= HCW'(1)) begin
          sda_oe    <= drv_tgt;
          hold_pend <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end
      if (scl_fall) begin
        hold_cnt  <= HCW'(HOLD_CYC);
        hold_pend <= 1'b1;
      end

      if (start_c || stop_c) begin
        state     <= start_c ? ST_ADDR : ST_IDLE;
        bit_cnt   <= '0;
        drv_tgt   <= 1'b0;
        hold_pend <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sr   <= {rx_sr[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (rx_sr[7:1] == {DEV_BASE, addr_sel}) begin
                state   <= ST_ADDR_ACK;
                rw_q    <= rx_sr[0];
                drv_tgt <= 1'b1;
              end else begin
                state   <= ST_IDLE;
                drv_tgt <= 1'b0;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                state   <= ST_RD_DATA;
                drv_tgt <= ~rd_data[7];
                tx_sr   <= {rd_data[6:0], 1'b0};
                bit_cnt <= 4'd1;
              end else begin
                state   <= ST_WR_DATA;
                drv_tgt <= 1'b0;
                bit_cnt <= '0;
                first_q <= 1'b1;
              end
            end
          end
          ST_WR_DATA: begin
            if (scl_rise) begin
              rx_sr   <= {rx_sr[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              state   <= ST_WR_ACK;
              drv_tgt <= 1'b1;
              if (first_q) begin
                ptr     <= rx_sr[AW-1:0];
                first_q <= 1'b0;
              end else begin
                wr_req  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_sr;
                ptr     <= ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              state   <= ST_WR_DATA;
              drv_tgt <= 1'b0;
              bit_cnt <= '0;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                state   <= ST_RD_ACK;
                drv_tgt <= 1'b0;
                ptr     <= ptr + 1'b1;
              end else begin
                drv_tgt <= ~tx_sr[7];
                tx_sr   <= {tx_sr[6:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_f;
            end else if (scl_fall) begin
              if (nack_q) begin
                state   <= ST_IDLE;
                drv_tgt <= 1'b0;
              end else begin
                state   <= ST_RD_DATA;
                drv_tgt <= ~rd_data[7];
                tx_sr   <= {rd_data[6:0], 1'b0};
                bit_cnt <= 4'd1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_pull_only_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  assert_no_change_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_f) |=> $stable(sda_oe));

  assert_silent_in_address_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |-> !sda_oe);

  assert_released_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE && !hold_pend) |-> !sda_oe);
endmodule

// File: tb/i2cs_regslave_tb.sv
module i2cs_regslave_tb;
  localparam int Q        = 40;
  localparam int GUARD_US = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, guard_viol;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2cs_regslave #(.GUARD_US(GUARD_US)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .addr_sel  (addr_sel),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .guard_viol(guard_viol)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Each entry: {register, value}; all below the guarded range.
  localparam logic [15:0] VEC [4] = '{16'h00A5, 16'h0F3C, 16'h7E81, 16'hEF5A};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bit(input logic b, input logic glitch, output logic seen);
    if (glitch) begin
      scl_m = 1'b1; tick(3);
      scl_m = 1'b0;
    end
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 4, s);
    send_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, 1'b0, s);
      d[i] = s;
    end
    send_bit(last, 1'b0, s);
  endtask

  // Single-register write; ok is the AND of all acknowledges.
  task automatic wr1(input logic [7:0] ra, input logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h98, 1'b0, a0);
    send_byte(ra, 1'b0, a1);
    send_byte(v, 1'b0, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  // Pointer write, repeated START, read n bytes into buf.
  task automatic rdn(input logic [7:0] ra, input int n, output logic [7:0] buf0,
                     output logic [7:0] buf1, output logic [7:0] buf2, output logic ok);
    logic a0, a1, a2;
    logic [7:0] d;
    bus_start();
    send_byte(8'h98, 1'b0, a0);
    send_byte(ra, 1'b0, a1);
    bus_start();
    send_byte(8'h99, 1'b0, a2);
    buf0 = 8'h00; buf1 = 8'h00; buf2 = 8'h00;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      if (k == 0) buf0 = d;
      if (k == 1) buf1 = d;
      if (k == 2) buf2 = d;
    end
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok, a;
    logic [7:0] r0, r1, r2;

    tick(10);
    rst = 1'b0;
    tick(5);
    check("R9 sda released", {7'd0, sda_oe}, 8'h00);
    check("R9 flag clear", {7'd0, guard_viol}, 8'h00);

    // Table-driven write then read-back through repeated START.
    for (int v = 0; v < 4; v++) begin
      wr1(VEC[v][15:8], VEC[v][7:0], ok);
      check("R1 R3 write acked", {7'd0, ok}, 8'h01);
      rdn(VEC[v][15:8], 1, r0, r1, r2, ok);
      check("R5 R4 readback", r0, VEC[v][7:0]);
    end

    // R3/R4: multi-byte write with auto-increment, sequential read.
    bus_start();
    send_byte(8'h98, 1'b0, a);
    send_byte(8'h20, 1'b0, a);
    send_byte(8'h11, 1'b0, a);
    send_byte(8'h22, 1'b0, a);
    send_byte(8'h33, 1'b0, ok);
    bus_stop();
    check("R3 last data byte acked", {7'd0, ok}, 8'h01);
    rdn(8'h20, 3, r0, r1, r2, ok);
    check("R4 seq byte0", r0, 8'h11);
    check("R4 seq byte1", r1, 8'h22);
    check("R4 seq byte2", r2, 8'h33);
    check("R4 released after NACK", {7'd0, sda_oe}, 8'h00);

    // R1/R2: strap high moves the address to 0x4D.
    addr_sel = 1'b1;
    tick(4);
    bus_start();
    send_byte(8'h98, 1'b0, a);
    check("R2 0x4C refused with strap high", {7'd0, a}, 8'h00);
    send_byte(8'h00, 1'b0, a);
    check("R2 later byte ignored", {7'd0, a}, 8'h00);
    bus_start();
    send_byte(8'h9A, 1'b0, a);
    check("R1 R5 0x4D acked after restart", {7'd0, a}, 8'h01);
    bus_stop();
    addr_sel = 1'b0;
    tick(4);

    // R10: short SCL pulse inside a data byte is filtered out.
    bus_start();
    send_byte(8'h98, 1'b0, a);
    send_byte(8'h40, 1'b0, a);
    send_byte(8'hC3, 1'b1, a);
    bus_stop();
    rdn(8'h40, 1, r0, r1, r2, ok);
    check("R10 glitch ignored", r0, 8'hC3);

    // R7/R8: guarded range spacing.
    wr1(8'hF3, 8'h5A, ok);
    check("R8 first guarded write flag", {7'd0, guard_viol}, 8'h00);
    tick(GUARD_US * 100 + 1000);
    bus_start();
    send_byte(8'h98, 1'b0, a);
    send_byte(8'hF2, 1'b0, a);
    send_byte(8'h11, 1'b0, a);
    send_byte(8'h22, 1'b0, ok);
    bus_stop();
    check("R7 early write still acked", {7'd0, ok}, 8'h01);
    check("R7 flag set", {7'd0, guard_viol}, 8'h01);
    rdn(8'hF2, 2, r0, r1, r2, ok);
    check("R8 spaced write stored", r0, 8'h11);
    check("R7 early write dropped", r1, 8'h5A);

    tick(GUARD_US * 100 + 1000);
    bus_start();
    send_byte(8'h98, 1'b0, a);
    send_byte(8'hFF, 1'b0, a);
    send_byte(8'h6B, 1'b0, a);
    send_byte(8'h7C, 1'b0, a);
    bus_stop();
    rdn(8'hFF, 2, r0, r1, r2, ok);
    check("R8 guarded write at 0xFF", r0, 8'h6B);
    check("R8 R3 wrap to 0x00 not blocked", r1, 8'h7C);
    check("R7 flag sticky", {7'd0, guard_viol}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule